// File: doc/BRIEF.md
# Buffered Multi-Word Flash Program Sequencer

This block sits behind a simple synchronous host write port and turns a run of command writes into one buffered program operation on a flash array. The host opens the operation with a two-write unlock handshake. It then writes a buffer-load command at an address inside the target sector, followed by a word count. Next it writes up to sixteen address/data pairs that all fall in one sixteen-word page of that sector, and closes with a confirm command at the sector. The buffered words are then committed into an internal register model of the array.

Programming follows flash semantics. A stored bit can only go from 1 to 0, so every committed word becomes the old contents ANDed with the new data. Any violation of the sequence, such as a bad count, a load outside the page or a misplaced confirm, leaves the block in a sticky abort state. Only a reset command clears that state. After a good confirm the block reports busy for a fixed, parameterised number of cycles and then pulses done. The array can be read at any time through a combinational read port.

Top module: `wbuf_prog_ctrl`

## Requirements
- R1: After reset, busy, done and abort are low and every array word reads FFFFh.
- R2: An operation opens only with AAh written at word address 555h, then 55h at 2AAh, then 25h at any address (which selects the sector, address bits from the top down to SECT_LSB). A wrong second or third write returns the block to idle without raising abort. Command words carry a zero upper byte.
- R3: The write following the buffer-load command must hit the same sector and carries the number of words minus one. A value above 15, or a write to another sector, raises abort. A value of 15 (sixteen words) is accepted.
- R4: The first loaded pair selects the page (address bits from the top down to bit 4) and must lie in the selected sector. Any later load whose page differs raises abort.
- R5: Pairs may be loaded in any order within the page. The remaining count drops by one on every load, repeated addresses included, and the last data written to a location is the one programmed.
- R6: A write of 0029h at the sector after the final load commits the buffer. Each loaded location becomes old AND new, and page locations never loaded keep their contents.
- R7: A write of 0029h at the sector while loads remain, or any other write once the final load is done, raises abort and programs nothing.
- R8: Abort stays high and all writes are ignored until 00F0h is written at any address, which returns the block to idle.
- R9: Busy is high for exactly BUSY_CYC cycles starting with the cycle after the confirm write. Done is high for the single cycle that follows, and host writes during busy are ignored.
- R10: The committed data is visible on rd_data in the first cycle after the confirm write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Host word address |
| wr_data | input | DW | Host write data or command word |
| rd_addr | input | ARR_AW | Array read address |
| rd_data | output | DW | Array word at rd_addr |
| busy | output | 1 | Commit in progress |
| done | output | 1 | One-cycle pulse when busy ends |
| abort | output | 1 | Sticky sequence-error flag |

## Verification
The bench builds the block with SECT_LSB set to 6, so four whole sectors lie inside the 256-word array model. Sector-mismatch and page-mismatch aborts can then be provoked and their effect on real array contents read back without address aliasing. BUSY_CYC is set to 5, which keeps the busy window short enough to walk cycle by cycle, including a write injected in the middle of it. The default sixteen-entry buffer lets the full-count boundary and the overflow count both be exercised.

// File: rtl/wbp_pkg.sv
// Package: shared command codes, fixed unlock addresses and the
// sequencer state type for the buffered program controller.
// Assumes command words are compared with a zero upper byte.
package wbp_pkg;

    localparam int unsigned ADR_UNLK1 = 'h555;
    localparam int unsigned ADR_UNLK2 = 'h2AA;

    localparam logic [7:0] CMD_UNLK1 = 8'hAA;
    localparam logic [7:0] CMD_UNLK2 = 8'h55;
    localparam logic [7:0] CMD_BUFLD = 8'h25;
    localparam logic [7:0] CMD_CONF  = 8'h29;
    localparam logic [7:0] CMD_RST   = 8'hF0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_CNT,
        ST_LOAD,
        ST_CONF,
        ST_BUSY,
        ST_ABORT
    } seq_state_t;

endpackage

// File: rtl/wbp_buf.sv
// Module: write buffer of N entries, one valid bit per entry.
// Clearing drops every valid bit; a load overwrites its entry.
// Assumes entry data needs no reset because valid gates its use.
module wbp_buf #(
    parameter int DW = 16,
    parameter int N  = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   ld,
    input  logic [IDX_W-1:0]       ld_idx,
    input  logic [DW-1:0]          ld_data,
    output logic [N-1:0][DW-1:0]   ent_data,
    output logic [N-1:0]           ent_vld
);

    // Valid bits: cleared on reset or new operation, set on load.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ent_vld <= '0;
        end else if (ld) begin
            ent_vld[ld_idx] <= 1'b1;
        end
    end

    // Entry data: last load to an index wins.
    always_ff @(posedge clk) begin
        if (ld) begin
            ent_data[ld_idx] <= ld_data;
        end
    end

endmodule

// File: rtl/wbp_array.sv
// Module: register model of the flash array, 2**ARR_AW words.
// Reset erases every word to all ones. A commit ANDs each valid
// buffer entry into the word at {page, entry index}, keeping the
// low ARR_AW bits of that address. Reads are combinational.
module wbp_array #(
    parameter int ADDR_W = 12,
    parameter int DW     = 16,
    parameter int N      = 16,
    parameter int ARR_AW = 8,
    localparam int IDX_W = $clog2(N),
    localparam int PG_W  = ADDR_W - IDX_W,
    localparam int DEPTH = 1 << ARR_AW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit,
    input  logic [PG_W-1:0]        page,
    input  logic [N-1:0][DW-1:0]   ent_data,
    input  logic [N-1:0]           ent_vld,
    input  logic [ARR_AW-1:0]      rd_addr,
    output logic [DW-1:0]          rd_data
);

    logic [DW-1:0]              mem [DEPTH];
    logic [N-1:0][ARR_AW-1:0]   slot;

    // One array slot per buffer entry for the selected page.
    for (genvar g = 0; g < N; g++) begin : g_slot
        logic [ADDR_W-1:0] full_adr;
        assign full_adr = {page, IDX_W'(g)};
        assign slot[g]  = full_adr[ARR_AW-1:0];
    end

    // Storage: erase on reset, bit-clearing commit otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (commit) begin
            for (int i = 0; i < N; i++) begin
                if (ent_vld[i]) begin
                    mem[slot[i]] <= mem[slot[i]] & ent_data[i];
                end
            end
        end
    end

    // Read port.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/wbp_seq.sv
// Module: command sequencer. Decodes unlock, buffer-load, count,
// pair loads and confirm; enforces sector and page rules; runs the
// busy timer and the sticky abort state.
// Assumes SECT_LSB > log2(N), BUSY_CYC >= 1, DW >= 8.
module wbp_seq
    import wbp_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DW       = 16,
    parameter int N        = 16,
    parameter int SECT_LSB = 8,
    parameter int BUSY_CYC = 8,
    localparam int IDX_W = $clog2(N),
    localparam int PG_W  = ADDR_W - IDX_W,
    localparam int SC_W  = ADDR_W - SECT_LSB,
    localparam int REM_W = IDX_W + 1,
    localparam int TMR_W = $clog2(BUSY_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              buf_clr,
    output logic              buf_ld,
    output logic [IDX_W-1:0]  buf_idx,
    output logic              commit,
    output logic [PG_W-1:0]   page,
    output logic              busy,
    output logic              done,
    output logic              abort
);

    seq_state_t         st_q, st_nxt;
    logic [SC_W-1:0]    sect_q;
    logic [PG_W-1:0]    page_q;
    logic               first_q;
    logic [REM_W-1:0]   rem_q;
    logic [TMR_W-1:0]   tmr_q;
    logic               done_q;

    logic [SC_W-1:0]    wr_sect;
    logic [PG_W-1:0]    wr_page;
    logic               sect_hit, page_ok, cnt_bad;
    logic               is_unl1, is_unl2, is_bufld, is_conf, is_rst;

    // Address fields and command-word matches of the current write.
    always_comb begin
        wr_sect  = wr_addr[ADDR_W-1:SECT_LSB];
        wr_page  = wr_addr[ADDR_W-1:IDX_W];
        sect_hit = (wr_sect == sect_q);
        page_ok  = first_q ? sect_hit : (wr_page == page_q);
        cnt_bad  = (wr_data > DW'(N - 1));
        is_unl1  = (wr_data == DW'(CMD_UNLK1)) && (wr_addr == ADDR_W'(ADR_UNLK1));
        is_unl2  = (wr_data == DW'(CMD_UNLK2)) && (wr_addr == ADDR_W'(ADR_UNLK2));
        is_bufld = (wr_data == DW'(CMD_BUFLD));
        is_conf  = (wr_data == DW'(CMD_CONF)) && sect_hit;
        is_rst   = (wr_data == DW'(CMD_RST));
    end

    // Next state and one-cycle strobes to the buffer and array.
    always_comb begin
        st_nxt  = st_q;
        buf_clr = 1'b0;
        buf_ld  = 1'b0;
        commit  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (wr_en && is_unl1) st_nxt = ST_UNL1;
            end
            ST_UNL1: begin
                if (wr_en) st_nxt = is_unl2 ? ST_UNL2 : ST_IDLE;
            end
            ST_UNL2: begin
                if (wr_en) begin
                    if (is_bufld) begin
                        st_nxt  = ST_CNT;
                        buf_clr = 1'b1;
                    end else begin
                        st_nxt = ST_IDLE;
                    end
                end
            end
            ST_CNT: begin
                if (wr_en) st_nxt = (!sect_hit || cnt_bad) ? ST_ABORT : ST_LOAD;
            end
            ST_LOAD: begin
                if (wr_en) begin
                    if (is_conf || !page_ok) begin
                        st_nxt = ST_ABORT;
                    end else begin
                        buf_ld = 1'b1;
                        if (rem_q == REM_W'(1)) st_nxt = ST_CONF;
                    end
                end
            end
            ST_CONF: begin
                if (wr_en) begin
                    if (is_conf) begin
                        st_nxt = ST_BUSY;
                        commit = 1'b1;
                    end else begin
                        st_nxt = ST_ABORT;
                    end
                end
            end
            ST_BUSY: begin
                if (tmr_q == '0) st_nxt = ST_IDLE;
            end
            ST_ABORT: begin
                if (wr_en && is_rst) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // Sector latch on the buffer-load command.
    always_ff @(posedge clk) begin
        if (!rst_n)       sect_q <= '0;
        else if (buf_clr) sect_q <= wr_sect;
    end

    // Remaining-load counter and first-load flag; page latch on first load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            first_q <= 1'b0;
            page_q  <= '0;
        end else if (st_q == ST_CNT && wr_en) begin
            rem_q   <= REM_W'(wr_data[IDX_W-1:0]) + REM_W'(1);
            first_q <= 1'b1;
        end else if (buf_ld) begin
            rem_q   <= rem_q - REM_W'(1);
            first_q <= 1'b0;
            if (first_q) page_q <= wr_page;
        end
    end

    // Busy timer: loaded by the commit, counts down while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)                          tmr_q <= '0;
        else if (commit)                     tmr_q <= TMR_W'(BUSY_CYC - 1);
        else if (st_q == ST_BUSY && tmr_q != '0) tmr_q <= tmr_q - TMR_W'(1);
    end

    // Done pulse in the cycle after the last busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (st_q == ST_BUSY) && (tmr_q == '0);
    end

    assign buf_idx = wr_addr[IDX_W-1:0];
    assign page    = page_q;
    assign busy    = (st_q == ST_BUSY);
    assign abort   = (st_q == ST_ABORT);
    assign done    = done_q;

endmodule

// File: rtl/wbuf_prog_ctrl.sv
// Module: top of the buffered program controller. Wires the command
// sequencer, the write buffer and the array model together.
// Assumes one host write per cycle and SECT_LSB above the page bits.
module wbuf_prog_ctrl #(
    parameter int ADDR_W   = 12,
    parameter int DW       = 16,
    parameter int N        = 16,
    parameter int SECT_LSB = 8,
    parameter int ARR_AW   = 8,
    parameter int BUSY_CYC = 8,
    localparam int IDX_W = $clog2(N),
    localparam int PG_W  = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ARR_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              busy,
    output logic              done,
    output logic              abort
);

    logic                   buf_clr_w, buf_ld_w, commit_w;
    logic [IDX_W-1:0]       buf_idx_w;
    logic [PG_W-1:0]        page_w;
    logic [N-1:0][DW-1:0]   ent_data_w;
    logic [N-1:0]           ent_vld_w;

    wbp_seq #(
        .ADDR_W(ADDR_W), .DW(DW), .N(N),
        .SECT_LSB(SECT_LSB), .BUSY_CYC(BUSY_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .buf_clr(buf_clr_w), .buf_ld(buf_ld_w), .buf_idx(buf_idx_w),
        .commit(commit_w), .page(page_w),
        .busy(busy), .done(done), .abort(abort)
    );

    wbp_buf #(.DW(DW), .N(N)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .clr(buf_clr_w), .ld(buf_ld_w), .ld_idx(buf_idx_w), .ld_data(wr_data),
        .ent_data(ent_data_w), .ent_vld(ent_vld_w)
    );

    wbp_array #(.ADDR_W(ADDR_W), .DW(DW), .N(N), .ARR_AW(ARR_AW)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .commit(commit_w), .page(page_w),
        .ent_data(ent_data_w), .ent_vld(ent_vld_w),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

endmodule

// File: rtl/wbp_chk.sv
// Module: assertion checker for wbuf_prog_ctrl, attached by bind.
// Watches the status outputs, the read port and the commit strobe.
module wbp_chk #(
    parameter int DW       = 16,
    parameter int ARR_AW   = 8,
    parameter int BUSY_CYC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DW-1:0]     wr_data,
    input logic [ARR_AW-1:0] rd_addr,
    input logic [DW-1:0]     rd_data,
    input logic              busy,
    input logic              done,
    input logic              abort,
    input logic              commit
);

    logic [31:0] bcnt;

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt <= '0;
        else if (busy) bcnt <= bcnt + 32'd1;
        else           bcnt <= '0;
    end

    assert_busy_abort_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && abort));

    assert_abort_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !(wr_en && wr_data == DW'(8'hF0))) |=> abort);

    assert_commit_starts_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);

    assert_busy_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));

    assert_busy_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt < 32'(BUSY_CYC)));

    assert_done_after_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bcnt == 32'(BUSY_CYC)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_bits_only_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(rd_addr) |-> ((rd_data & ~$past(rd_data)) == '0));

endmodule

bind wbuf_prog_ctrl wbp_chk #(
    .DW(DW), .ARR_AW(ARR_AW), .BUSY_CYC(BUSY_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .abort(abort), .commit(commit_w)
);

// File: tb/sim_wbuf_prog_ctrl.sv
`timescale 1ns/1ps
// Bench: vector table for one full program run, then directed tests.
module sim_wbuf_prog_ctrl;

    localparam int ADDR_W = 12;
    localparam int DW     = 16;
    localparam int ARR_AW = 8;
    localparam int BCYC   = 5;
    localparam int NVEC   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DW-1:0]     wr_data = '0;
    logic [ARR_AW-1:0] rd_addr = '0;
    logic [DW-1:0]     rd_data;
    logic              busy, done, abort;

    int n_chk = 0;
    int n_bad = 0;

    // Entry: {addr[11:0], data[15:0], expected abort, expected busy}.
    localparam logic [29:0] VEC [NVEC] = '{
        {12'h555, 16'h00AA, 1'b0, 1'b0},
        {12'h2AA, 16'h0055, 1'b0, 1'b0},
        {12'h040, 16'h0025, 1'b0, 1'b0},
        {12'h040, 16'h0002, 1'b0, 1'b0},
        {12'h053, 16'hFF00, 1'b0, 1'b0},
        {12'h050, 16'h1234, 1'b0, 1'b0},
        {12'h050, 16'h0F0F, 1'b0, 1'b0},
        {12'h040, 16'h0029, 1'b0, 1'b1}
    };

    always #10 clk = ~clk;

    wbuf_prog_ctrl #(
        .ADDR_W(ADDR_W), .DW(DW), .N(16), .SECT_LSB(6),
        .ARR_AW(ARR_AW), .BUSY_CYC(BCYC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .abort(abort)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; one write cycle; returns at the next negedge.
    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        chk(req, 32'(rd_data), 32'(exp));
    endtask

    task automatic head(input logic [11:0] s, input logic [15:0] cnt);
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
        wr(s, 16'h0025);
        wr(s, cnt);
    endtask

    task automatic wait_done(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
        chk(req, 32'(seen), 32'd1);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 abort", 32'(abort), 0);
        rdchk("R1 erased", 8'h50, 16'hFFFF);
        rdchk("R1 erased", 8'hFF, 16'hFFFF);

        // R2 R5 R6: table-driven program run, loads out of order with a repeat
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][29:18], VEC[i][17:2]);
            chk("R2 table abort", 32'(abort), 32'(VEC[i][1]));
            chk("R5 table busy", 32'(busy), 32'(VEC[i][0]));
        end
        wait_done("R9 done after table run");
        rdchk("R5 last data wins", 8'h50, 16'h0F0F);
        rdchk("R5 any order", 8'h53, 16'hFF00);
        rdchk("R6 unloaded kept", 8'h51, 16'hFFFF);

        // R6: second program to same word is an AND
        head(12'h040, 16'h0000);
        wr(12'h050, 16'hF0F0);
        wr(12'h040, 16'h0029);
        wait_done("R6 done");
        rdchk("R6 and with old", 8'h50, 16'h0000);
        rdchk("R6 neighbour kept", 8'h53, 16'hFF00);

        // R2: broken unlock returns to idle without abort
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0056);
        wr(12'h0C0, 16'h0025);
        wr(12'h0C0, 16'h0000);
        wr(12'h0C5, 16'h0000);
        wr(12'h0C0, 16'h0029);
        chk("R2 no abort", 32'(abort), 0);
        chk("R2 no busy", 32'(busy), 0);
        rdchk("R2 nothing written", 8'hC5, 16'hFFFF);

        // R3 R8: count above 15 aborts; abort sticky; F0 clears
        head(12'h0C0, 16'h0010);
        chk("R3 count 16 aborts", 32'(abort), 1);
        wr(12'h0C5, 16'h0000);
        head(12'h0C0, 16'h0000);
        wr(12'h0C0, 16'h0029);
        chk("R8 abort sticky", 32'(abort), 1);
        chk("R8 no busy in abort", 32'(busy), 0);
        rdchk("R8 writes ignored", 8'hC5, 16'hFFFF);
        wr(12'h123, 16'h00F0);
        chk("R8 F0 clears", 32'(abort), 0);

        // R3: count at another sector aborts
        head(12'h0C0, 16'h0001);
        chk("R3 sector ok count", 32'(abort), 0);
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h0C0, 16'h00F0);
        // the line above left state idle via F0-free path? ensure clean: reset cmd
        wr(12'h000, 16'h00F0);
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h0C0, 16'h0025);
        wr(12'h080, 16'h0001);
        chk("R3 count other sector", 32'(abort), 1);
        wr(12'h000, 16'h00F0);

        // R3 R5: full sixteen-word load accepted
        head(12'h0C0, 16'h000F);
        chk("R3 count 15 accepted", 32'(abort), 0);
        for (int i = 15; i >= 0; i--) wr(12'h0C0 | 12'(i), 16'hA5A0 | 16'(i));
        chk("R5 sixteen loads no abort", 32'(abort), 0);
        wr(12'h0C0, 16'h0029);
        chk("R3 full buffer commits", 32'(busy), 1);
        wait_done("R3 done");
        rdchk("R3 entry 0", 8'hC0, 16'hA5A0);
        rdchk("R3 entry 15", 8'hCF, 16'hA5AF);

        // R4: first load outside sector aborts
        head(12'h080, 16'h0000);
        wr(12'h0C1, 16'h0000);
        chk("R4 first load other sector", 32'(abort), 1);
        wr(12'h000, 16'h00F0);
        rdchk("R4 untouched", 8'hC1, 16'hA5A1);

        // R4: later load in another page aborts
        head(12'h080, 16'h0001);
        wr(12'h091, 16'h0000);
        wr(12'h0A1, 16'h0000);
        chk("R4 page change aborts", 32'(abort), 1);
        wr(12'h000, 16'h00F0);
        rdchk("R4 nothing programmed", 8'h91, 16'hFFFF);

        // R7: early confirm aborts
        head(12'h080, 16'h0001);
        wr(12'h092, 16'h0000);
        wr(12'h080, 16'h0029);
        chk("R7 early confirm", 32'(abort), 1);
        wr(12'h000, 16'h00F0);
        rdchk("R7 early nothing programmed", 8'h92, 16'hFFFF);

        // R7: wrong write after final load aborts
        head(12'h080, 16'h0000);
        wr(12'h093, 16'h0000);
        wr(12'h080, 16'h0025);
        chk("R7 non-confirm after final", 32'(abort), 1);
        wr(12'h000, 16'h00F0);
        rdchk("R7 late nothing programmed", 8'h93, 16'hFFFF);

        // R9 R10: busy window, write during busy ignored
        head(12'h080, 16'h0000);
        wr(12'h085, 16'h00FF);
        wr(12'h080, 16'h0029);
        chk("R9 busy cycle 1", 32'(busy), 1);
        rdchk("R10 data next cycle", 8'h85, 16'h00FF);
        wr(12'h085, 16'h0000);
        chk("R9 busy cycle 2", 32'(busy), 1);
        for (int i = 3; i <= BCYC; i++) begin
            @(negedge clk);
            chk("R9 busy held", 32'(busy), 1);
            chk("R9 no early done", 32'(done), 0);
        end
        @(negedge clk);
        chk("R9 busy ends", 32'(busy), 0);
        chk("R9 done pulse", 32'(done), 1);
        @(negedge clk);
        chk("R9 done one cycle", 32'(done), 0);
        rdchk("R9 busy write ignored", 8'h85, 16'h00FF);
        chk("R9 no abort", 32'(abort), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule